// File: doc/BRIEF.md
# Multi-Format Output Sample Formatter

This block sits at the end of a channel datapath. It takes a 32-bit fractional two's complement sample and rewrites it into one of several narrower output representations before the sample goes to a serial or parallel output stage. It can truncate to 8 or 32 bits or round to 16 or 24 bits. It can also pack the sample into a 12-bit floating point word with a 4-bit exponent and an 8-bit signed mantissa. The floating point word spans about 138 dB.

A 3-bit format code is captured together with each input sample. The formatted result is registered once. It appears one cycle after the input strobe, left-justified in a 32-bit word, along with the code it was produced under. Between strobes the output word holds its last value.

Top module: `sample_formatter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `out_valid` is 0, `out_word` is 0 and `out_fmt` is 0.
- R2: `out_valid` rises exactly one clock after a cycle with `in_valid` high and is low one clock after a cycle with `in_valid` low. `out_fmt` then equals the `in_fmt` captured with that sample.
- R3: Code 0 (8-bit truncation) gives `out_word = {in_data[31:24], 24'h0}`.
- R4: Code 1 (16-bit rounding) gives `out_word[31:16] = in_data[31:16] + in_data[15]` (round half up) and `out_word[15:0] = 0`.
- R5: Code 2 (24-bit rounding) gives `out_word[31:8] = in_data[31:8] + in_data[7]` and `out_word[7:0] = 0`.
- R6: Code 3 (32-bit truncation) passes `in_data` through unchanged.
- R7: If rounding would carry a positive sample past the largest code, the result saturates. For code 1 this is 0x7FFF in the upper half. For code 2 it is 0x7FFFFF in the upper 24 bits. Negative samples never saturate.
- R8: Code 4 (float) has an exponent of 15 minus the count of redundant sign bits. A redundant sign bit is a bit below bit 31 that matches bit 31 in the unbroken run starting at bit 30. The exponent is clamped to 0 when that count exceeds 15.
- R9: The float mantissa is bits [31:24] of `in_data` shifted left by (15 − exponent). The 12-bit word {exponent, mantissa} sits in `out_word[31:20]`, and `out_word[19:0]` is 0.
- R10: Codes 5, 6 and 7 are reserved. They give `out_word = 0` and are still echoed on `out_fmt`.
- R11: In a cycle with `in_valid` low, `out_word` and `out_fmt` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 32 | Fractional two's complement sample |
| in_fmt | input | 3 | Format code captured with the sample |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_word | output | 32 | Left-justified formatted result |
| out_fmt | output | 3 | Format code of the current result |

## Verification
On every cycle the assertions check the following:
- the one-cycle strobe latency and the echo of the format code;
- that the unused low bits are zero for each narrow format;
- that a nonzero exponent always comes with a mantissa whose top two bits differ;
- the rounding saturation;
- that outputs hold between strobes.

Only the bench's directed scenarios can show that the rounded values are correct. The same goes for the exponent at each normalization depth, the clamp at small magnitudes, negative samples at the half-LSB boundary and back-to-back samples with changing codes.

// File: rtl/sample_formatter.sv
module sample_formatter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic [2:0]  in_fmt,
  output logic        out_valid,
  output logic [31:0] out_word,
  output logic [2:0]  out_fmt
);

  localparam logic [2:0] FMT_T8  = 3'd0;
  localparam logic [2:0] FMT_R16 = 3'd1;
  localparam logic [2:0] FMT_R24 = 3'd2;
  localparam logic [2:0] FMT_T32 = 3'd3;
  localparam logic [2:0] FMT_FLT = 3'd4;
  localparam int         MAX_EXP = 15;

  logic        sat16, sat24;
  logic [15:0] rnd16;
  logic [23:0] rnd24;

  assign sat16 = (in_data[31:16] == 16'h7FFF) && in_data[15];
  assign sat24 = (in_data[31:8] == 24'h7FFFFF) && in_data[7];
  assign rnd16 = sat16 ? 16'h7FFF   : in_data[31:16] + {15'd0, in_data[15]};
  assign rnd24 = sat24 ? 24'h7FFFFF : in_data[31:8]  + {23'd0, in_data[7]};

  logic [4:0]  rsb;
  logic        run;
  logic [3:0]  shamt;
  logic [3:0]  fexp;
  logic [31:0] norm;
  logic [7:0]  fmant;

  always_comb begin
    rsb = 5'd0;
    run = 1'b1;
    for (int i = 30; i >= 0; i--) begin
      if (run && (in_data[i] == in_data[31])) rsb = rsb + 5'd1;
      else run = 1'b0;
    end
  end

  assign shamt = (rsb > 5'(MAX_EXP)) ? 4'(MAX_EXP) : rsb[3:0];
  assign fexp  = 4'(MAX_EXP) - shamt;
  assign norm  = in_data << shamt;
  assign fmant = norm[31:24];

  logic [31:0] fmt_word;

  always_comb begin
    case (in_fmt)
      FMT_T8:  fmt_word = {in_data[31:24], 24'd0};
      FMT_R16: fmt_word = {rnd16, 16'd0};
      FMT_R24: fmt_word = {rnd24, 8'd0};
      FMT_T32: fmt_word = in_data;
      FMT_FLT: fmt_word = {fexp, fmant, 20'd0};
      default: fmt_word = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= 32'd0;
      out_fmt   <= 3'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= fmt_word;
        out_fmt  <= in_fmt;
      end
    end
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  fmt_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_fmt == $past(in_fmt)));
  // R3
  t8_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == FMT_T8) |-> (out_word[23:0] == 24'd0));
  // R4
  r16_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == FMT_R16) |-> (out_word[15:0] == 16'd0));
  // R5
  r24_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == FMT_R24) |-> (out_word[7:0] == 8'd0));
  // R7
  r16_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_fmt == FMT_R16 && in_data[31:15] == 17'h0FFFF)
      |=> (out_word == 32'h7FFF_0000));
  // R7
  r24_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_fmt == FMT_R24 && in_data[31:7] == 25'h0FFFFFF)
      |=> (out_word == 32'h7FFF_FF00));
  // R8
  flt_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == FMT_FLT && out_word[31:28] != 4'd0)
      |-> (out_word[27] != out_word[26]));
  // R9
  flt_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == FMT_FLT) |-> (out_word[19:0] == 20'd0));
  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt > FMT_FLT) |-> (out_word == 32'd0));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_word) && $stable(out_fmt)));

endmodule

// File: tb/sim_sample_formatter.sv
module sim_sample_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = 32'd0;
  logic [2:0]  in_fmt = 3'd0;
  logic        out_valid;
  logic [31:0] out_word;
  logic [2:0]  out_fmt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sample_formatter u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_fmt(in_fmt), .out_valid(out_valid), .out_word(out_word), .out_fmt(out_fmt));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [31:0] d, input logic [2:0] f,
                       input logic [31:0] exp);
    @(negedge clk);
    in_data = d; in_fmt = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " fmt"}, {29'd0, out_fmt}, {29'd0, f});
    check(req, out_word, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 word", out_word, 32'd0);
    check("R1 fmt", {29'd0, out_fmt}, 32'd0);
  endtask

  task automatic t_trunc;
    apply("R3 t8 pos", 32'h1234_5678, 3'd0, 32'h1200_0000);
    apply("R3 t8 neg", 32'h80FF_FFFF, 3'd0, 32'h8000_0000);
    apply("R6 t32", 32'hDEAD_BEEF, 3'd3, 32'hDEAD_BEEF);
  endtask

  task automatic t_round;
    apply("R4 below half", 32'h1234_7FFF, 3'd1, 32'h1234_0000);
    apply("R4 at half", 32'h1234_8000, 3'd1, 32'h1235_0000);
    apply("R4 neg half", 32'hFFFF_8000, 3'd1, 32'h0000_0000);
    apply("R5 below half", 32'h1234_567F, 3'd2, 32'h1234_5600);
    apply("R5 at half", 32'h1234_5680, 3'd2, 32'h1234_5700);
    apply("R7 sat16", 32'h7FFF_8000, 3'd1, 32'h7FFF_0000);
    apply("R7 sat24", 32'h7FFF_FF80, 3'd2, 32'h7FFF_FF00);
    apply("R7 neg no sat", 32'h8000_8000, 3'd1, 32'h8001_0000);
  endtask

  task automatic t_float;
    apply("R8 full scale", 32'h4000_0000, 3'd4, 32'hF400_0000);
    apply("R8 shift8", 32'h0040_0000, 3'd4, 32'h7400_0000);
    apply("R9 negative", 32'hFF00_0000, 3'd4, 32'h8800_0000);
    apply("R9 min neg", 32'h8000_0000, 3'd4, 32'hF800_0000);
    apply("R8 exp1", 32'h0001_2345, 3'd4, 32'h1480_0000);
    apply("R8 clamp small", 32'h0000_0100, 3'd4, 32'h0000_0000);
    apply("R8 clamp minus1", 32'hFFFF_FFFF, 3'd4, 32'h0FF0_0000);
    apply("R8 zero", 32'h0000_0000, 3'd4, 32'h0000_0000);
  endtask

  task automatic t_reserved;
    apply("R10 code5", 32'h1234_5678, 3'd5, 32'h0000_0000);
    apply("R10 code7", 32'hFFFF_FFFF, 3'd7, 32'h0000_0000);
  endtask

  task automatic t_hold;
    apply("R11 setup", 32'hCAFE_F00D, 3'd3, 32'hCAFE_F00D);
    @(negedge clk);
    in_data = 32'h1111_1111; in_fmt = 3'd0;
    @(negedge clk);
    check("R2 idle valid", {31'd0, out_valid}, 32'd0);
    check("R11 word", out_word, 32'hCAFE_F00D);
    check("R11 fmt", {29'd0, out_fmt}, 32'd3);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    in_data = 32'h1234_8000; in_fmt = 3'd1; in_valid = 1'b1;
    @(negedge clk);
    check("R2 b2b first", out_word, 32'h1235_0000);
    in_data = 32'h0040_0000; in_fmt = 3'd4;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 b2b second", out_word, 32'h7400_0000);
    check("R2 b2b fmt", {29'd0, out_fmt}, 32'd4);
    check("R2 b2b valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R2 b2b drop", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    t_reset();
    t_trunc();
    t_round();
    t_float();
    t_reserved();
    t_hold();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule